// File: doc/BRIEF.md
# DDR Command Arbiter with Refresh Interleave and Starvation Guard

This block chooses, every clock cycle, at most one command for the SDRAM command sequencer. Each master queue presents one head candidate: a read or a write with a bank, row, column, priority level and an age stamp taken when the command was queued. The bank tracker reports which row is open in each bank. A refresh controller supplies three urgency flags, and a power manager may ask for self-refresh entry.

Reads and writes are ranked separately. A candidate that hits an open row comes first, then the better priority level, then the older stamp. The best read is then weighed against the best write, using how full the read-data FIFO is and their priorities. The refresh urgencies are placed between the read and write classes. A transfer counter with a programmable limit gives a temporary boost to the oldest queued command, so that a steady stream of favoured traffic cannot starve it. The result leaves on a valid/ready handshake. On acceptance, a one-hot take vector tells the winning master queue to advance.

Top module: `ddr_cmd_sched`

## Requirements
- R1: Within one class (reads, or writes), a candidate whose row is open in its bank wins over a candidate whose row is closed, whatever their priority levels and stamps.
- R2: Among candidates of one class with the same open-row status, the smaller priority value wins (0 is the best). When priorities are equal, the smaller age stamp wins.
- R3: A read is never offered while `rd_fifo_full` is high. When a read and a write are both eligible, the read goes first unless the write's priority is strictly better (a promoted write counts as better than any read that is not promoted). In that case the write goes first.
- R4: Grant order from highest to lowest: refresh with `ref_must`; a read chosen under R3; refresh with `ref_need`; a write; refresh with `ref_may`; self-refresh entry with `sref_req`.
- R5: `cmd_kind` encodes 0 read, 1 write, 2 refresh, 3 self-refresh entry. For a data command, `cmd_master`, `cmd_bank`, `cmd_row` and `cmd_col` name the winner. `cand_take` is one-hot on the winner only in a cycle where `cmd_valid` and `cmd_ready` are both high, and zero otherwise. At most one grant is made per cycle.
- R6: With `raise_limit` at 8'hFF, no command is ever promoted, and the R1/R2 ranking holds indefinitely.
- R7: With `raise_limit` = N below 8'hFF, the guard waits for N accepted reads or writes counted since reset or since the last promotion. On the next clock edge after that count is reached, with any candidate present, it promotes the valid candidate with the smallest stamp. The promoted command outranks open-row status and priority within its class.
- R8: A promoted command keeps its promotion until it is accepted, even across cycles in which `cmd_ready` is low. The transfer count restarts from zero when a promotion fires. After the promoted command issues, the ordinary ranking returns.
- R9: After reset, with no requests present, `cmd_valid` and `cand_take` are low and no promotion is in effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cand_valid | input | NUM_MASTERS | Head candidate present, per master |
| cand_write | input | NUM_MASTERS | 1 = write, 0 = read, per master |
| cand_bank | input | NUM_MASTERS*BANK_W | Bank of each candidate |
| cand_row | input | NUM_MASTERS*ROW_W | Row of each candidate |
| cand_col | input | NUM_MASTERS*COL_W | Column of each candidate |
| cand_prio | input | NUM_MASTERS*PRIO_W | Priority level, 0 best |
| cand_stamp | input | NUM_MASTERS*STAMP_W | Enqueue stamp, smaller is older |
| bank_open | input | 2**BANK_W | A row is open in this bank |
| open_row | input | 2**BANK_W*ROW_W | Open row number per bank |
| rd_fifo_full | input | 1 | Read-data FIFO cannot take more |
| ref_must | input | 1 | Refresh at highest urgency |
| ref_need | input | 1 | Refresh at middle urgency |
| ref_may | input | 1 | Refresh at lowest urgency |
| sref_req | input | 1 | Request to enter self-refresh |
| raise_limit | input | RAISE_W | Transfers before promotion; all ones disables |
| cmd_valid | output | 1 | A command is offered |
| cmd_ready | input | 1 | Sequencer accepts the offered command |
| cmd_kind | output | 2 | 0 read, 1 write, 2 refresh, 3 self-refresh |
| cmd_bank | output | BANK_W | Bank of a data command |
| cmd_row | output | ROW_W | Row of a data command |
| cmd_col | output | COL_W | Column of a data command |
| cmd_master | output | MID_W | Master that supplied the data command |
| cand_take | output | NUM_MASTERS | One-hot pop to the winning master queue |

## Verification
The bench builds the block with its defaults: four masters, eight banks, three priority bits and eight-bit stamps. Four masters are enough to have an open-row, a closed-row, a better-priority and an older candidate in contention together. Because `raise_limit` is a port, the bench can set it to 0 and 2. That brings promotion within a few cycles of reset, so the exact firing edge, the hold across a stalled handshake and the return to normal ranking can all be observed. The bench also holds the limit at its disabled value over many transfers.

// File: rtl/ddr_sched_pkg.sv
package ddr_sched_pkg;

    parameter int BANK_W  = 3;
    parameter int ROW_W   = 13;
    parameter int COL_W   = 10;
    parameter int PRIO_W  = 3;
    parameter int STAMP_W = 8;
    parameter int RAISE_W = 8;

    localparam int NUM_BANKS = 1 << BANK_W;
    localparam int KEY_W     = 2 + PRIO_W + STAMP_W;
    localparam logic [RAISE_W-1:0] RAISE_OFF = '1;

    typedef enum logic [1:0] {
        CMD_RD   = 2'd0,
        CMD_WR   = 2'd1,
        CMD_REF  = 2'd2,
        CMD_SREF = 2'd3
    } cmd_kind_e;

    typedef struct packed {
        logic               vld;
        logic               wr;
        logic [BANK_W-1:0]  bank;
        logic [ROW_W-1:0]   row;
        logic [COL_W-1:0]   col;
        logic [PRIO_W-1:0]  prio;
        logic [STAMP_W-1:0] stamp;
    } cand_t;

    // Smaller key wins: promotion, then open row, then priority, then age.
    function automatic logic [KEY_W-1:0] rank_key(
        input logic               promoted,
        input logic               row_hit,
        input logic [PRIO_W-1:0]  prio,
        input logic [STAMP_W-1:0] stamp
    );
        return {~promoted, ~row_hit, prio, stamp};
    endfunction

endpackage

// File: rtl/sched_class_pick.sv
module sched_class_pick
    import ddr_sched_pkg::*;
#(
    parameter int NUM_MASTERS = 4,
    parameter int MID_W       = 2
) (
    input  logic [NUM_MASTERS-1:0] req,
    input  logic [NUM_MASTERS-1:0] promo,
    input  logic [NUM_MASTERS-1:0] hit,
    input  logic [PRIO_W-1:0]      prio  [NUM_MASTERS],
    input  logic [STAMP_W-1:0]     stamp [NUM_MASTERS],
    output logic                   found,
    output logic [MID_W-1:0]       win_idx,
    output logic                   win_promo,
    output logic [PRIO_W-1:0]      win_prio
);

    logic [KEY_W-1:0] best_key;

    always_comb begin
        found     = 1'b0;
        win_idx   = '0;
        win_promo = 1'b0;
        win_prio  = '0;
        best_key  = '1;
        for (int i = 0; i < NUM_MASTERS; i++) begin
            if (req[i] && (!found ||
                    rank_key(promo[i], hit[i], prio[i], stamp[i]) < best_key)) begin
                found     = 1'b1;
                win_idx   = MID_W'(i);
                win_promo = promo[i];
                win_prio  = prio[i];
                best_key  = rank_key(promo[i], hit[i], prio[i], stamp[i]);
            end
        end
    end

endmodule

// File: rtl/sched_promote.sv
module sched_promote
    import ddr_sched_pkg::*;
#(
    parameter int NUM_MASTERS = 4,
    parameter int MID_W       = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [RAISE_W-1:0]     raise_limit,
    input  logic [NUM_MASTERS-1:0] vld,
    input  logic [STAMP_W-1:0]     stamp [NUM_MASTERS],
    input  logic                   xfer_done,
    input  logic [MID_W-1:0]       done_mid,
    output logic                   promo_on,
    output logic [MID_W-1:0]       promo_mid
);

    logic [RAISE_W-1:0] xfer_cnt;
    logic               any_vld;
    logic [MID_W-1:0]   oldest_mid;
    logic [STAMP_W-1:0] oldest_stamp;
    logic               fire;
    logic               promo_issued;

    always_comb begin
        any_vld      = 1'b0;
        oldest_mid   = '0;
        oldest_stamp = '1;
        for (int i = 0; i < NUM_MASTERS; i++) begin
            if (vld[i] && (!any_vld || stamp[i] < oldest_stamp)) begin
                any_vld      = 1'b1;
                oldest_mid   = MID_W'(i);
                oldest_stamp = stamp[i];
            end
        end
    end

    assign fire = !promo_on && (raise_limit != RAISE_OFF) &&
                  (xfer_cnt >= raise_limit) && any_vld;
    assign promo_issued = promo_on && xfer_done && (done_mid == promo_mid);

    always_ff @(posedge clk) begin
        if (rst) begin
            xfer_cnt  <= '0;
            promo_on  <= 1'b0;
            promo_mid <= '0;
        end else begin
            if (fire) begin
                promo_on  <= 1'b1;
                promo_mid <= oldest_mid;
                xfer_cnt  <= '0;
            end else begin
                if (promo_issued || (promo_on && !vld[promo_mid]))
                    promo_on <= 1'b0;
                if (xfer_done && xfer_cnt != '1)
                    xfer_cnt <= xfer_cnt + 1'b1;
            end
        end
    end

    AST_OFF_NO_PROMO: assert property (@(posedge clk) disable iff (rst)
        (raise_limit == RAISE_OFF && !promo_on) |=> !promo_on); // R6

    AST_PROMO_HOLD: assert property (@(posedge clk) disable iff (rst)
        (promo_on && !promo_issued && vld[promo_mid]) |=>
        (promo_on && $stable(promo_mid))); // R8

    AST_COUNT_RESTART: assert property (@(posedge clk) disable iff (rst)
        $rose(promo_on) |-> (xfer_cnt == '0)); // R8

endmodule

// File: rtl/ddr_cmd_sched.sv
module ddr_cmd_sched
    import ddr_sched_pkg::*;
#(
    parameter int NUM_MASTERS = 4,
    localparam int MID_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NUM_MASTERS-1:0]         cand_valid,
    input  logic [NUM_MASTERS-1:0]         cand_write,
    input  logic [NUM_MASTERS*BANK_W-1:0]  cand_bank,
    input  logic [NUM_MASTERS*ROW_W-1:0]   cand_row,
    input  logic [NUM_MASTERS*COL_W-1:0]   cand_col,
    input  logic [NUM_MASTERS*PRIO_W-1:0]  cand_prio,
    input  logic [NUM_MASTERS*STAMP_W-1:0] cand_stamp,
    input  logic [NUM_BANKS-1:0]           bank_open,
    input  logic [NUM_BANKS*ROW_W-1:0]     open_row,
    input  logic                           rd_fifo_full,
    input  logic                           ref_must,
    input  logic                           ref_need,
    input  logic                           ref_may,
    input  logic                           sref_req,
    input  logic [RAISE_W-1:0]             raise_limit,
    output logic                           cmd_valid,
    input  logic                           cmd_ready,
    output logic [1:0]                     cmd_kind,
    output logic [BANK_W-1:0]              cmd_bank,
    output logic [ROW_W-1:0]               cmd_row,
    output logic [COL_W-1:0]               cmd_col,
    output logic [MID_W-1:0]               cmd_master,
    output logic [NUM_MASTERS-1:0]         cand_take
);

    cand_t              cands [NUM_MASTERS];
    logic [PRIO_W-1:0]  prio_a  [NUM_MASTERS];
    logic [STAMP_W-1:0] stamp_a [NUM_MASTERS];
    logic [NUM_MASTERS-1:0] hit, promo_vec;
    logic [NUM_MASTERS-1:0] cls_req [2];

    logic               cls_found [2];
    logic [MID_W-1:0]   cls_idx   [2];
    logic               cls_promo [2];
    logic [PRIO_W-1:0]  cls_prio  [2];

    logic               promo_on;
    logic [MID_W-1:0]   promo_mid;
    logic               rd_ok, wr_beats, take_rd, is_data, xfer_done;
    logic [MID_W-1:0]   data_idx;
    cmd_kind_e          kind;

    always_comb begin
        for (int i = 0; i < NUM_MASTERS; i++) begin
            cands[i].vld   = cand_valid[i];
            cands[i].wr    = cand_write[i];
            cands[i].bank  = cand_bank[i*BANK_W +: BANK_W];
            cands[i].row   = cand_row[i*ROW_W +: ROW_W];
            cands[i].col   = cand_col[i*COL_W +: COL_W];
            cands[i].prio  = cand_prio[i*PRIO_W +: PRIO_W];
            cands[i].stamp = cand_stamp[i*STAMP_W +: STAMP_W];
            prio_a[i]      = cands[i].prio;
            stamp_a[i]     = cands[i].stamp;
            hit[i]         = bank_open[cands[i].bank] &&
                             (open_row[cands[i].bank*ROW_W +: ROW_W] == cands[i].row);
            promo_vec[i]   = promo_on && (promo_mid == MID_W'(i));
            cls_req[0][i]  = cands[i].vld && !cands[i].wr;
            cls_req[1][i]  = cands[i].vld &&  cands[i].wr;
        end
    end

    // Class 0 ranks reads, class 1 ranks writes.
    for (genvar g = 0; g < 2; g++) begin : g_cls
        sched_class_pick #(
            .NUM_MASTERS (NUM_MASTERS),
            .MID_W       (MID_W)
        ) u_pick (
            .req       (cls_req[g]),
            .promo     (promo_vec),
            .hit       (hit),
            .prio      (prio_a),
            .stamp     (stamp_a),
            .found     (cls_found[g]),
            .win_idx   (cls_idx[g]),
            .win_promo (cls_promo[g]),
            .win_prio  (cls_prio[g])
        );
    end

    sched_promote #(
        .NUM_MASTERS (NUM_MASTERS),
        .MID_W       (MID_W)
    ) u_promote (
        .clk         (clk),
        .rst         (rst),
        .raise_limit (raise_limit),
        .vld         (cand_valid),
        .stamp       (stamp_a),
        .xfer_done   (xfer_done),
        .done_mid    (data_idx),
        .promo_on    (promo_on),
        .promo_mid   (promo_mid)
    );

    always_comb begin
        rd_ok    = cls_found[0] && !rd_fifo_full;
        wr_beats = cls_found[1] &&
                   ({~cls_promo[1], cls_prio[1]} < {~cls_promo[0], cls_prio[0]});
        take_rd  = rd_ok && !wr_beats;

        cmd_valid = 1'b1;
        kind      = CMD_REF;
        if (ref_must)          kind = CMD_REF;
        else if (take_rd)      kind = CMD_RD;
        else if (ref_need)     kind = CMD_REF;
        else if (cls_found[1]) kind = CMD_WR;
        else if (ref_may)      kind = CMD_REF;
        else if (sref_req)     kind = CMD_SREF;
        else                   cmd_valid = 1'b0;

        is_data  = cmd_valid && (kind == CMD_RD || kind == CMD_WR);
        data_idx = (kind == CMD_RD) ? cls_idx[0] : cls_idx[1];

        cmd_kind   = kind;
        cmd_master = is_data ? data_idx : '0;
        cmd_bank   = is_data ? cands[data_idx].bank : '0;
        cmd_row    = is_data ? cands[data_idx].row  : '0;
        cmd_col    = is_data ? cands[data_idx].col  : '0;

        xfer_done  = is_data && cmd_ready;
        cand_take  = '0;
        if (xfer_done) cand_take[data_idx] = 1'b1;
    end

    AST_SINGLE_TAKE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cand_take)); // R5

    AST_TAKE_NEEDS_HS: assert property (@(posedge clk) disable iff (rst)
        (|cand_take) |-> (cmd_valid && cmd_ready)); // R5

    AST_NO_RD_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && rd_fifo_full) |-> (cmd_kind != 2'd0)); // R3

    AST_MUST_WINS: assert property (@(posedge clk) disable iff (rst)
        ref_must |-> (cmd_valid && cmd_kind == 2'd2)); // R4

endmodule

// File: tb/tb_ddr_cmd_sched.sv
`timescale 1ns/1ps
module tb_ddr_cmd_sched;
    import ddr_sched_pkg::*;

    localparam int NM    = 4;
    localparam int MID_W = 2;
    localparam int HALF  = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #HALF clk = ~clk;

    logic [NM-1:0]         c_vld, c_wr;
    logic [NM*BANK_W-1:0]  c_bank;
    logic [NM*ROW_W-1:0]   c_row;
    logic [NM*COL_W-1:0]   c_col;
    logic [NM*PRIO_W-1:0]  c_prio;
    logic [NM*STAMP_W-1:0] c_stamp;
    logic [NUM_BANKS-1:0]  b_open;
    logic [NUM_BANKS*ROW_W-1:0] b_row;
    logic rfull, rmust, rneed, rmay, sreq, ready;
    logic [RAISE_W-1:0] limit;

    logic               cmd_valid;
    logic [1:0]         cmd_kind;
    logic [BANK_W-1:0]  cmd_bank;
    logic [ROW_W-1:0]   cmd_row;
    logic [COL_W-1:0]   cmd_col;
    logic [MID_W-1:0]   cmd_master;
    logic [NM-1:0]      cand_take;

    ddr_cmd_sched #(.NUM_MASTERS(NM)) dut (
        .clk(clk), .rst(rst),
        .cand_valid(c_vld), .cand_write(c_wr), .cand_bank(c_bank),
        .cand_row(c_row), .cand_col(c_col), .cand_prio(c_prio),
        .cand_stamp(c_stamp), .bank_open(b_open), .open_row(b_row),
        .rd_fifo_full(rfull), .ref_must(rmust), .ref_need(rneed),
        .ref_may(rmay), .sref_req(sreq), .raise_limit(limit),
        .cmd_valid(cmd_valid), .cmd_ready(ready), .cmd_kind(cmd_kind),
        .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col),
        .cmd_master(cmd_master), .cand_take(cand_take)
    );

    typedef struct {
        int    kind;
        int    mid;
        int    row;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    task automatic clear_all();
        c_vld = '0; c_wr = '0; c_bank = '0; c_row = '0; c_col = '0;
        c_prio = '0; c_stamp = '0; b_open = '0; b_row = '0;
        rfull = 0; rmust = 0; rneed = 0; rmay = 0; sreq = 0; ready = 0;
    endtask

    task automatic put(int m, bit wr, int bank, int row, int prio, int stamp);
        c_vld[m] = 1'b1;
        c_wr[m]  = wr;
        c_bank[m*BANK_W +: BANK_W]    = BANK_W'(bank);
        c_row[m*ROW_W +: ROW_W]       = ROW_W'(row);
        c_col[m*COL_W +: COL_W]       = COL_W'(m + 3);
        c_prio[m*PRIO_W +: PRIO_W]    = PRIO_W'(prio);
        c_stamp[m*STAMP_W +: STAMP_W] = STAMP_W'(stamp);
    endtask

    task automatic open_bank(int bank, int row);
        b_open[bank] = 1'b1;
        b_row[bank*ROW_W +: ROW_W] = ROW_W'(row);
    endtask

    task automatic expect_grant(int kind, int mid, int row, string tag);
        exp_t e;
        e.kind = kind; e.mid = mid; e.row = row; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic check(bit ok, string tag, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic step();
        @(negedge clk); #1;
    endtask

    // Monitor: compares each accepted command with the scoreboard head.
    initial begin
        forever begin
            @(negedge clk); #8;
            if (!rst && cmd_valid && ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "unexpected grant", int'(cmd_kind), -1);
                end else begin
                    exp_t e;
                    int   want_take;
                    e = exp_q.pop_front();
                    check(int'(cmd_kind) == e.kind, {e.tag, " kind"}, int'(cmd_kind), e.kind);
                    want_take = 0;
                    if (e.kind < 2) begin
                        want_take = 1 << e.mid;
                        check(int'(cmd_master) == e.mid, {e.tag, " master"}, int'(cmd_master), e.mid);
                        check(int'(cmd_row) == e.row, {e.tag, " row"}, int'(cmd_row), e.row);
                        check(int'(cmd_col) == e.mid + 3, {e.tag, " col"}, int'(cmd_col), e.mid + 3);
                    end
                    check(int'(cand_take) == want_take, {e.tag, " take R5"}, int'(cand_take), want_take);
                end
            end
        end
    end

    task automatic do_reset(int lim);
        @(negedge clk); #1;
        rst = 1'b1; clear_all(); limit = RAISE_W'(lim);
        repeat (3) @(negedge clk);
        #1;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(2 * HALF * 20000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            summary();
            $finish;
        end
    end

    initial begin
        clear_all();
        limit = '1;
        do_reset(255);

        // R9: idle after reset
        rst = 1'b0;
        #6;
        check(cmd_valid == 1'b0, "R9 idle valid", int'(cmd_valid), 0);
        check(cand_take == '0, "R9 idle take", int'(cand_take), 0);

        // R1: open row beats better priority and age
        step(); clear_all(); ready = 1;
        put(0, 0, 1, 5, 0, 1);
        put(1, 0, 2, 7, 3, 9);
        open_bank(2, 7); open_bank(1, 6);
        expect_grant(0, 1, 7, "R1 open row read");

        // R2: priority, then age
        step(); clear_all(); ready = 1;
        put(0, 0, 1, 11, 2, 1);
        put(2, 0, 3, 12, 1, 5);
        expect_grant(0, 2, 12, "R2 better prio");
        step(); clear_all(); ready = 1;
        put(0, 0, 1, 13, 1, 4);
        put(3, 0, 3, 14, 1, 2);
        expect_grant(0, 3, 14, "R2 older stamp");

        // R3: read vs write
        step(); clear_all(); ready = 1;
        put(0, 0, 1, 20, 1, 1);
        put(1, 1, 2, 21, 1, 0);
        expect_grant(0, 0, 20, "R3 read first");
        step(); rfull = 1;
        expect_grant(1, 1, 21, "R3 fifo full write");
        step(); clear_all(); ready = 1;
        put(0, 0, 1, 22, 2, 1);
        put(1, 1, 2, 23, 0, 5);
        expect_grant(1, 1, 23, "R3 higher prio write");
        step(); clear_all();
        put(0, 0, 1, 24, 0, 1); rfull = 1;
        #6;
        check(cmd_valid == 1'b0, "R3 read held when full", int'(cmd_valid), 0);

        // R4: grant ladder
        step(); clear_all(); ready = 1;
        put(0, 0, 1, 30, 0, 1); rmust = 1;
        expect_grant(2, 0, 0, "R4 must over read");
        step(); rmust = 0; rneed = 1;
        expect_grant(0, 0, 30, "R4 read over need");
        step(); clear_all(); ready = 1;
        put(1, 1, 1, 31, 0, 1); rneed = 1;
        expect_grant(2, 0, 0, "R4 need over write");
        step(); rneed = 0; rmay = 1;
        expect_grant(1, 1, 31, "R4 write over may");
        step(); clear_all(); ready = 1; rmay = 1; sreq = 1;
        expect_grant(2, 0, 0, "R4 may over sref");
        step(); rmay = 0;
        expect_grant(3, 0, 0, "R4 sref alone");

        // R5: stalled handshake gives no take
        step(); clear_all();
        put(2, 0, 4, 40, 0, 1);
        #6;
        check(cmd_valid == 1'b1 && cmd_kind == 2'd0, "R5 offered read", int'(cmd_kind), 0);
        check(cmd_master == 2'd2, "R5 master", int'(cmd_master), 2);
        check(cand_take == '0, "R5 no take on stall", int'(cand_take), 0);

        // R6: disabled guard never promotes
        do_reset(255);
        rst = 1'b0; ready = 1;
        put(0, 0, 1, 50, 0, 9);
        put(1, 0, 2, 51, 7, 1);
        open_bank(1, 50);
        expect_grant(0, 0, 50, "R6 no promotion");
        for (int k = 0; k < 5; k++) begin
            step();
            expect_grant(0, 0, 50, "R6 no promotion");
        end

        // R7: limit 2, promotion after two transfers plus one edge
        do_reset(2);
        rst = 1'b0; ready = 1;
        put(0, 0, 1, 60, 0, 10);
        put(1, 0, 2, 61, 7, 1);
        open_bank(1, 60);
        expect_grant(0, 0, 60, "R7 before count");
        step(); expect_grant(0, 0, 60, "R7 before count");
        step(); expect_grant(0, 0, 60, "R7 count reached");
        step(); expect_grant(0, 1, 61, "R7 oldest promoted");
        step(); expect_grant(0, 0, 60, "R8 ranking restored");

        // R8: promotion held while stalled; promoted write beats read
        do_reset(0);
        rst = 1'b0;
        put(2, 1, 3, 70, 7, 0);
        put(1, 0, 1, 71, 0, 5);
        open_bank(1, 71);
        for (int k = 0; k < 3; k++) begin
            step(); #6;
            check(cmd_kind == 2'd1 && cmd_master == 2'd2, "R8 promoted write held",
                  int'(cmd_master), 2);
        end
        step(); ready = 1;
        expect_grant(1, 2, 70, "R8 promoted issue");
        step(); c_vld[2] = 1'b0;
        expect_grant(0, 1, 71, "R8 after promoted");

        step(); ready = 0;
        step();
        done = 1'b1;
        check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        summary();
        $finish;
    end

endmodule